// File: doc/BRIEF.md
# Strobe-Handshaked Cascadable FIFO

A first-in first-out buffer of 64 words built from a register array that has separate write and read pointers. The sender and the receiver each use a level strobe paired with a ready flag. The sender watches the input-ready flag and raises its strobe to hand over a word. The receiver watches the output-ready flag, takes the word shown on the data outputs, and drops its strobe to move to the next word. The whole block runs on one system clock. Both strobes are sampled in that clock, and their edges are found inside the block.

Each strobe does its work on its two edges. On the sender side, the word is captured while the strobe is high and the write pointer moves when the strobe falls. On the receiver side, the word is claimed when the strobe rises and the read pointer moves when the strobe falls. A word entering an empty buffer becomes visible at the output a fixed, parameterised number of clocks after its write completes. A slot freed in a full buffer reaches the input side after the same delay. An output enable floats the data outputs, so several buffers can share one bus.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer empties. After that edge `in_ready_o` is 1 and `out_ready_o` is 0. With the output enable high, `data_o` reads all zeros.
- R2: A word on `data_i` is captured at a clock edge where both `in_ready_o` and `shift_in_i` are high. From the next cycle `in_ready_o` stays low until the falling edge of `shift_in_i` has been sampled.
- R3: The sampled fall of `shift_in_i` after a capture completes the write. In the next cycle `in_ready_o` is high again unless the buffer now holds `DEPTH` words.
- R4: For a word written into an empty buffer, `out_ready_o` rises exactly `LAT` clocks after the edge that completed the write, and `data_o` shows that word.
- R5: A rising edge of `shift_out_i` sampled while `out_ready_o` is high claims the head word. `out_ready_o` is low in the next cycle, and `data_o` keeps the head word until the strobe falls.
- R6: The fall of `shift_out_i` after a claim removes the head word. In the next cycle `out_ready_o` is high with the following word if one remains. Otherwise `out_ready_o` is 0 and `data_o` reads zero.
- R7: A rise of `shift_out_i` seen while `out_ready_o` is low is ignored. So is a fall that was not preceded by a claim. Neither removes a word.
- R8: A full buffer holds `DEPTH` words and keeps `in_ready_o` low. A strobe pulse on `shift_in_i` that begins and ends while the buffer is full stores nothing.
- R9: If `shift_in_i` is still high when a read frees a slot in a full buffer, `in_ready_o` rises `LAT` clocks after the read completes. The waiting word is then captured as one more entry.
- R10: When `out_en_i` is low, `data_o` is high-impedance. Two buffers tied to one bus therefore deliver the data of whichever one is enabled.
- R11: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| shift_in_i | input | 1 | Level strobe from the sender |
| data_i | input | W | Word to be written |
| in_ready_o | output | 1 | High when a word can be accepted |
| shift_out_i | input | 1 | Level strobe from the receiver |
| out_ready_o | output | 1 | High when the head word is valid on the outputs |
| out_en_i | input | 1 | High drives `data_o`, low floats it |
| data_o | output | W | Head word, zero when empty, high-impedance when disabled |

## Verification
The assertions watch every cycle for four things: both ready flags drop the cycle after a capture or a claim; the head word holds steady while a claim is outstanding; the pointer distance never exceeds the depth; and a receiver rise while output-ready is low never creates a claim. Other behaviours can only be shown by the bench's scenarios, because they depend on a sequence of stimulus. These are the exact write-to-output latency, the order of data through a full buffer, the rejection of a strobe pulse while full, the late capture of a held strobe once a slot frees, and the sharing of a bus between two enabled and disabled buffers.

// File: rtl/sfifo_pkg.sv
// Shared types for the strobe-handshaked FIFO.
// Assumes: nothing beyond the standard language.
package sfifo_pkg;
    // Edge events decoded from one sampled strobe level
    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_edge_t;
endpackage

// File: rtl/sfifo_strobe_edge.sv
// Finds the rising and falling edges of a level strobe sampled in the clock domain.
// Assumes: the strobe is already synchronous to clk; the level resets to low.
module sfifo_strobe_edge
    import sfifo_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_i,
    output strobe_edge_t edge_o
);
    logic level_q;

    // Hold last cycle's strobe level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign edge_o.rise = level_i && !level_q;
    assign edge_o.fall = !level_i && level_q;
endmodule

// File: rtl/sfifo_wrap_ptr.sv
// Pointer counter with an extra wrap bit for full/empty detection.
// Assumes: depth is a power of two, so the pointer wraps naturally.
module sfifo_wrap_ptr #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [PW-1:0] ptr_o
);
    // Advance by one on each completed transfer
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_o <= '0;
        else if (step_i) ptr_o <= ptr_o + 1'b1;
    end

    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(ptr_o));
endmodule

// File: rtl/sfifo_ptr_delay.sv
// Delays a pointer by LAT clocks; models the propagation time across the array.
// Assumes: LAT lies in 1..3.
module sfifo_ptr_delay #(
    parameter int PW  = 7,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ptr_i,
    output logic [PW-1:0] ptr_o
);
    logic [PW-1:0] stage [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage takes the live pointer
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= ptr_i;
            end
        end else begin : g_next
            // Later stages shift the previous stage on
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign ptr_o = stage[LAT-1];
endmodule

// File: rtl/sfifo_array.sv
// Dual-port register array: one synchronous write port, one combinational read port.
// Assumes: the controller never writes the slot being read while it is valid.
module sfifo_array #(
    parameter int W     = 4,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wen_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [DEPTH];

    // Store the incoming word at the write address
    always_ff @(posedge clk) begin
        if (wen_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/strobe_fifo.sv
// Strobe-handshaked FIFO. The sender strobe captures a word while high and commits it
// on its fall. The receiver strobe claims the head word on its rise and retires it on
// its fall. Each side sees the other's pointer through a LAT-clock delay.
// Assumes: strobes are synchronous to clk; DEPTH is a power of two; LAT in 1..3.
module strobe_fifo
    import sfifo_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 64,
    parameter int LAT   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_in_i,
    input  logic [W-1:0] data_i,
    output logic         in_ready_o,
    input  logic         shift_out_i,
    output logic         out_ready_o,
    input  logic         out_en_i,
    output logic [W-1:0] data_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    strobe_edge_t  si_ev, so_ev;
    logic [PW-1:0] wptr, rptr, wptr_seen, rptr_seen;
    logic          wr_busy, rd_busy;
    logic          full, empty;
    logic          wr_take, wr_done, rd_take, rd_done;
    logic [W-1:0]  head, drive;

    sfifo_strobe_edge u_si_edge (.clk(clk), .rst_n(rst_n), .level_i(shift_in_i),  .edge_o(si_ev));
    sfifo_strobe_edge u_so_edge (.clk(clk), .rst_n(rst_n), .level_i(shift_out_i), .edge_o(so_ev));

    sfifo_wrap_ptr #(.PW(PW)) u_wptr (.clk(clk), .rst_n(rst_n), .step_i(wr_done), .ptr_o(wptr));
    sfifo_wrap_ptr #(.PW(PW)) u_rptr (.clk(clk), .rst_n(rst_n), .step_i(rd_done), .ptr_o(rptr));

    sfifo_ptr_delay #(.PW(PW), .LAT(LAT)) u_w2r (
        .clk(clk), .rst_n(rst_n), .ptr_i(wptr), .ptr_o(wptr_seen));
    sfifo_ptr_delay #(.PW(PW), .LAT(LAT)) u_r2w (
        .clk(clk), .rst_n(rst_n), .ptr_i(rptr), .ptr_o(rptr_seen));

    sfifo_array #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .wen_i(wr_take), .waddr_i(wptr[AW-1:0]), .wdata_i(data_i),
        .raddr_i(rptr[AW-1:0]), .rdata_o(head));

    assign full  = (wptr[AW] != rptr_seen[AW]) && (wptr[AW-1:0] == rptr_seen[AW-1:0]);
    assign empty = (rptr == wptr_seen);

    assign in_ready_o  = !wr_busy && !full;
    assign out_ready_o = !rd_busy && !empty;

    assign wr_take = in_ready_o && shift_in_i;
    assign wr_done = wr_busy && si_ev.fall;
    assign rd_take = out_ready_o && so_ev.rise;
    assign rd_done = rd_busy && so_ev.fall;

    // Sender side: busy from capture until the strobe falls
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_busy <= 1'b0;
        else if (wr_take) wr_busy <= 1'b1;
        else if (wr_done) wr_busy <= 1'b0;
    end

    // Receiver side: busy from claim until the strobe falls
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_busy <= 1'b0;
        else if (rd_take) rd_busy <= 1'b1;
        else if (rd_done) rd_busy <= 1'b0;
    end

    assign drive  = empty ? '0 : head;
    assign data_o = out_en_i ? drive : 'z;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready_o && !out_ready_o));
    // R2
    take_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && shift_in_i) |=> !in_ready_o);
    // R5
    claim_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready_o && so_ev.rise) |=> !out_ready_o);
    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && $past(rd_busy)) |-> $stable(drive));
    // R7
    ignored_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_ev.rise && !out_ready_o && !rd_busy) |=> !rd_busy);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(wptr - rptr) <= PW'(DEPTH)));
endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
    localparam int W = 4;
    localparam int DEPTH = 64;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic si_a = 1'b0, so_a = 1'b0, oe_a = 1'b1;
    logic si_b = 1'b0, so_b = 1'b0, oe_b = 1'b0;
    logic [W-1:0] din_a = '0, din_b = '0;
    logic ir_a, or_a, ir_b, or_b;
    wire  [W-1:0] bus;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    strobe_fifo #(.W(W), .DEPTH(DEPTH), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_in_i(si_a), .data_i(din_a), .in_ready_o(ir_a),
        .shift_out_i(so_a), .out_ready_o(or_a), .out_en_i(oe_a), .data_o(bus));

    strobe_fifo #(.W(W), .DEPTH(DEPTH), .LAT(LAT)) peer_i (
        .clk(clk), .rst_n(rst_n), .shift_in_i(si_b), .data_i(din_b), .in_ready_o(ir_b),
        .shift_out_i(so_b), .out_ready_o(or_b), .out_en_i(oe_b), .data_o(bus));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [W-1:0] w);
        din_a = w; si_a = 1'b1;
        step(1);
        chk(ir_a == 1'b0, "R2 ready low after capture", int'(ir_a), 0);
        si_a = 1'b0;
        step(1);
    endtask

    task automatic pop(input logic [W-1:0] exp, input string tag);
        chk(or_a == 1'b1, {tag, " ready before read"}, int'(or_a), 1);
        chk(bus == exp, {tag, " head word"}, int'(bus), int'(exp));
        so_a = 1'b1;
        step(1);
        chk(or_a == 1'b0, "R5 ready low after claim", int'(or_a), 0);
        chk(bus == exp, "R5 word held during claim", int'(bus), int'(exp));
        so_a = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
        chk(ir_a == 1'b1, "R1 in ready", int'(ir_a), 1);
        chk(or_a == 1'b0, "R1 out ready", int'(or_a), 0);
        chk(bus == '0, "R1 data low", int'(bus), 0);
    endtask

    task automatic t_single();
        push(4'hA);
        chk(ir_a == 1'b1, "R3 ready back after fall", int'(ir_a), 1);
        step(LAT - 1);
        chk(or_a == 1'b0, "R4 not yet visible", int'(or_a), 0);
        step(1);
        chk(or_a == 1'b1, "R4 visible after latency", int'(or_a), 1);
        pop(4'hA, "R4");
        chk(or_a == 1'b0, "R6 empty after last read", int'(or_a), 0);
        chk(bus == '0, "R6 data zero when empty", int'(bus), 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 10; i++) push(W'(i * 7 + 3));
        step(LAT + 1);
        for (int i = 0; i < 10; i++) pop(W'(i * 7 + 3), "R11 order");
        chk(or_a == 1'b0, "R6 drained", int'(or_a), 0);
    endtask

    task automatic t_so_ignored();
        so_a = 1'b1; step(2);
        push(4'h5);
        step(LAT + 2);
        chk(or_a == 1'b1, "R7 early rise ignored", int'(or_a), 1);
        step(3);
        chk(or_a == 1'b1, "R7 still ready with strobe high", int'(or_a), 1);
        so_a = 1'b0; step(2);
        chk(or_a == 1'b1, "R7 unclaimed fall ignored", int'(or_a), 1);
        chk(bus == 4'h5, "R7 word kept", int'(bus), 5);
        pop(4'h5, "R7");
        chk(or_a == 1'b0, "R7 drained", int'(or_a), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(W'(i));
        chk(ir_a == 1'b0, "R8 full holds ready low", int'(ir_a), 0);
        din_a = 4'hF; si_a = 1'b1; step(1); si_a = 1'b0; step(2);
        chk(ir_a == 1'b0, "R8 still full after pulse", int'(ir_a), 0);
        din_a = 4'h9; si_a = 1'b1; step(2);
        pop(W'(0), "R9 first out");
        step(LAT + 2);
        si_a = 1'b0; step(2);
        chk(ir_a == 1'b0, "R9 held word filled slot", int'(ir_a), 0);
        for (int i = 1; i < DEPTH; i++) pop(W'(i), "R8 data");
        pop(4'h9, "R9 late word");
        chk(or_a == 1'b0, "R8 pulse word not stored", int'(or_a), 0);
    endtask

    task automatic t_bus();
        push(4'h3);
        din_b = 4'hC; si_b = 1'b1; step(1); si_b = 1'b0; step(1);
        step(LAT + 1);
        oe_a = 1'b1; oe_b = 1'b0; step(1);
        chk(bus == 4'h3, "R10 first buffer drives", int'(bus), 3);
        oe_a = 1'b0; oe_b = 1'b1; step(1);
        chk(bus == 4'hC, "R10 second buffer drives", int'(bus), 12);
        so_b = 1'b1; step(1); so_b = 1'b0; step(1);
        chk(or_b == 1'b0, "R10 second buffer drained", int'(or_b), 0);
        oe_b = 1'b0; oe_a = 1'b1; step(1);
        pop(4'h3, "R10");
    endtask

    initial begin
        t_reset();
        t_single();
        t_order();
        t_so_ignored();
        t_full();
        t_bus();
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule